// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block is the front end of an I2C target. It watches pre-synchronized SCL and SDA samples, finds START, repeated START and STOP conditions, and shifts in the address phase of every transfer, most significant bit first. It decides whether the slave is being addressed with either a 7-bit or a 10-bit address. On a match it emits a one-cycle `addr_match` pulse with a direction flag and pulls SDA low in the acknowledge slot.

The block keeps a flag once a full 10-bit write address has matched. A repeated START followed by the short read header (tag, the two upper address bits and R/W = 1) is then accepted on its own and reported as a read. A STOP produces a `stop_event` pulse. When the group-command option is on in 7-bit mode, that pulse is kept back unless the slave was addressed after the previous STOP. Several targets can then share one transaction that ends in a single STOP. Data bytes after the address phase are shifted but neither matched nor acknowledged.

Top module: `i2c_addr_recognizer`

## Requirements
- R1: After reset, and after any reset applied during a transfer, `addr_match`, `dir`, `stop_event` and `sda_oe` are 0. A remembered 10-bit selection is forgotten.
- R2: START is SDA falling while SCL is high. In 7-bit mode, the first byte after a START or repeated START is sampled on SCL rising edges, MSB first. If byte bits [7:1] equal `own_addr[6:0]`, `addr_match` pulses and `dir` takes byte bit 0 (1 = read).
- R3: A matching address byte is acknowledged: `sda_oe` is 1 while SCL is high in the ninth clock. A non-matching address byte and every data byte leave `sda_oe` at 0, and `sda_oe` changes only while SCL is low.
- R4: In 10-bit mode, a first byte of the form 11110, `own_addr[9:8]`, 0 is acknowledged with no `addr_match`. A following byte equal to `own_addr[7:0]` gives `addr_match` with `dir` = 0 and is acknowledged.
- R5: After a 10-bit write match, a repeated START followed by 11110, `own_addr[9:8]`, 1 gives `addr_match` with `dir` = 1 and is acknowledged.
- R6: A 10-bit read header without a full write match earlier in the same transfer gives no match and no acknowledge. This covers a header that follows a STOP and one that follows a rejected second byte.
- R7: STOP is SDA rising while SCL is high. It gives a one-cycle `stop_event` when group-command mode is off, or when 10-bit mode is selected.
- R8: With group-command mode on in 7-bit mode, a STOP gives `stop_event` only if `addr_match` pulsed since the previous STOP. Every STOP clears that history.
- R9: `addr_match` and `stop_event` never stay high for two consecutive cycles.
- R10: In 10-bit mode, a first byte whose tag or upper two bits differ from 11110 and `own_addr[9:8]` is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level (bus value) |
| own_addr | input | 10 | Slave address; bits [6:0] used in 7-bit mode |
| ten_bit_en | input | 1 | 1 selects 10-bit addressing |
| group_cmd_en | input | 1 | 1 enables STOP filtering for group commands |
| addr_match | output | 1 | One-cycle pulse on an address match |
| dir | output | 1 | Direction of the last match, 1 = read |
| stop_event | output | 1 | One-cycle pulse on a reported STOP |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |

## Verification
The assertions assume that SCL and SDA are already synchronized to `clk`. They also assume each SCL level is held for at least two clock cycles, so every edge and condition is seen once. A further assumption is that the controller starts and ends transfers only while the slave is not pulling SDA low. Under these assumptions, an `sda_oe` change is only valid in a cycle following SCL low. The bench's bus tasks hold every SCL phase for several cycles and change SDA only while SCL is low, except when forming START and STOP. The bench models the open-drain line as the controller's level ANDed with the inverted `sda_oe`, so acknowledges are read back from the shared wire.

// File: rtl/i2car_pkg.sv
package i2car_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_HDR,
      PH_TENLO,
      PH_SEL,
      PH_SKIP
   } phase_t;

   localparam logic [4:0] TEN_TAG = 5'b11110;
endpackage

// File: rtl/i2car_bus_events.sv
module i2car_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic start_o,
   output logic rstart_o,
   output logic stop_o,
   output logic scl_rise_o,
   output logic scl_fall_o
);
   logic scl_q, sda_q, busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
         busy_q <= 1'b0;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
         if (start_o)     busy_q <= 1'b1;
         else if (stop_o) busy_q <= 1'b0;
      end
   end

   assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
   assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
   assign rstart_o   = start_o & busy_q;
   assign scl_rise_o = scl_i & ~scl_q;
   assign scl_fall_o = ~scl_i & scl_q;
endmodule

// File: rtl/i2car_shifter.sv
module i2car_shifter #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              scl_rise_i,
   input  logic              scl_fall_i,
   input  logic              sda_i,
   input  logic              ack_req_i,
   output logic              byte_valid_o,
   output logic [BYTE_W-1:0] byte_o,
   output logic              sda_oe_o
);
   localparam int CW = $clog2(BYTE_W + 1);
   localparam logic [CW-1:0] ACK_SLOT = CW'(BYTE_W);
   localparam logic [CW-1:0] LAST_BIT = CW'(BYTE_W - 1);

   logic [CW-1:0]     cnt_q;
   logic [BYTE_W-2:0] sh_q;
   logic              active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         sh_q     <= '0;
         active_q <= 1'b0;
         sda_oe_o <= 1'b0;
      end else if (start_i || stop_i) begin
         cnt_q    <= '0;
         active_q <= start_i;
         sda_oe_o <= 1'b0;
      end else if (active_q) begin
         if (scl_rise_i) begin
            if (cnt_q == ACK_SLOT) begin
               cnt_q <= '0;
            end else begin
               sh_q  <= {sh_q[BYTE_W-3:0], sda_i};
               cnt_q <= cnt_q + 1'b1;
            end
         end
         if (scl_fall_i) sda_oe_o <= (cnt_q == ACK_SLOT) && ack_req_i;
      end
   end

   assign byte_valid_o = active_q & scl_rise_i & (cnt_q == LAST_BIT) & ~start_i & ~stop_i;
   assign byte_o       = {sh_q, sda_i};
endmodule

// File: rtl/i2car_addr_match.sv
module i2car_addr_match
   import i2car_pkg::*;
#(
   parameter int ADDR_W            = 10,
   parameter int BYTE_W            = 8,
   parameter bit GROUP_CMD_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              rstart_i,
   input  logic              stop_i,
   input  logic              byte_valid_i,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              ten_bit_en,
   input  logic              group_cmd_en,
   output logic              addr_match,
   output logic              dir,
   output logic              stop_event,
   output logic              ack_req
);
   localparam int SHORT_W = BYTE_W - 1;
   localparam int HI_W    = ADDR_W - BYTE_W;

   phase_t phase_q;
   logic   ten_mem_q, addressed_q, report;
   logic   hit7, hit10_hdr;

   assign hit7      = byte_i[BYTE_W-1:1] == own_addr[SHORT_W-1:0];
   assign hit10_hdr = (byte_i[BYTE_W-1:HI_W+1] == TEN_TAG) &&
                      (byte_i[HI_W:1] == own_addr[ADDR_W-1:BYTE_W]);

   generate
      if (GROUP_CMD_SUPPORT) begin : g_group
         assign report = !(group_cmd_en && !ten_bit_en) || addressed_q;
      end else begin : g_plain
         assign report = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= PH_IDLE;
         ten_mem_q   <= 1'b0;
         addressed_q <= 1'b0;
         addr_match  <= 1'b0;
         dir         <= 1'b0;
         stop_event  <= 1'b0;
         ack_req     <= 1'b0;
      end else begin
         addr_match <= 1'b0;
         stop_event <= 1'b0;
         if (stop_i) begin
            phase_q     <= PH_IDLE;
            ten_mem_q   <= 1'b0;
            ack_req     <= 1'b0;
            stop_event  <= report;
            addressed_q <= 1'b0;
         end else if (start_i) begin
            phase_q <= PH_HDR;
            ack_req <= 1'b0;
            if (!rstart_i) ten_mem_q <= 1'b0;
         end else if (byte_valid_i) begin
            ack_req <= 1'b0;
            phase_q <= PH_SKIP;
            unique case (phase_q)
               PH_HDR: begin
                  if (!ten_bit_en) begin
                     if (hit7) begin
                        addr_match  <= 1'b1;
                        dir         <= byte_i[0];
                        ack_req     <= 1'b1;
                        addressed_q <= 1'b1;
                        phase_q     <= PH_SEL;
                     end
                  end else if (hit10_hdr && !byte_i[0]) begin
                     ack_req <= 1'b1;
                     phase_q <= PH_TENLO;
                  end else if (hit10_hdr && ten_mem_q) begin
                     addr_match  <= 1'b1;
                     dir         <= 1'b1;
                     ack_req     <= 1'b1;
                     addressed_q <= 1'b1;
                     phase_q     <= PH_SEL;
                  end else begin
                     ten_mem_q <= 1'b0;
                  end
               end
               PH_TENLO: begin
                  if (byte_i == own_addr[BYTE_W-1:0]) begin
                     addr_match  <= 1'b1;
                     dir         <= 1'b0;
                     ack_req     <= 1'b1;
                     addressed_q <= 1'b1;
                     ten_mem_q   <= 1'b1;
                     phase_q     <= PH_SEL;
                  end else begin
                     ten_mem_q <= 1'b0;
                  end
               end
               PH_SEL:  phase_q <= PH_SEL;
               default: phase_q <= phase_q;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2c_addr_recognizer.sv
module i2c_addr_recognizer #(
   parameter int ADDR_W            = 10,
   parameter int BYTE_W            = 8,
   parameter bit GROUP_CMD_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              ten_bit_en,
   input  logic              group_cmd_en,
   output logic              addr_match,
   output logic              dir,
   output logic              stop_event,
   output logic              sda_oe
);
   generate
      if (BYTE_W != 8) begin : g_bad_byte
         $error("BYTE_W must be 8");
      end
      if (ADDR_W != 10) begin : g_bad_addr
         $error("ADDR_W must be 10");
      end
   endgenerate

   logic start, rstart, stop, scl_rise, scl_fall;
   logic byte_valid, ack_req;
   logic [BYTE_W-1:0] rx_byte;

   i2car_bus_events u_events (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .start_o    (start),
      .rstart_o   (rstart),
      .stop_o     (stop),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall)
   );

   i2car_shifter #(.BYTE_W(BYTE_W)) u_shift (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start),
      .stop_i       (stop),
      .scl_rise_i   (scl_rise),
      .scl_fall_i   (scl_fall),
      .sda_i        (sda_i),
      .ack_req_i    (ack_req),
      .byte_valid_o (byte_valid),
      .byte_o       (rx_byte),
      .sda_oe_o     (sda_oe)
   );

   i2car_addr_match #(
      .ADDR_W            (ADDR_W),
      .BYTE_W            (BYTE_W),
      .GROUP_CMD_SUPPORT (GROUP_CMD_SUPPORT)
   ) u_match (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start),
      .rstart_i     (rstart),
      .stop_i       (stop),
      .byte_valid_i (byte_valid),
      .byte_i       (rx_byte),
      .own_addr     (own_addr),
      .ten_bit_en   (ten_bit_en),
      .group_cmd_en (group_cmd_en),
      .addr_match   (addr_match),
      .dir          (dir),
      .stop_event   (stop_event),
      .ack_req      (ack_req)
   );
endmodule

// File: rtl/i2car_checker.sv
module i2car_checker (
   input logic clk,
   input logic rst_n,
   input logic scl_i,
   input logic ten_bit_en,
   input logic group_cmd_en,
   input logic addr_match,
   input logic stop_event,
   input logic sda_oe
);
   logic seen_match_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          seen_match_q <= 1'b0;
      else if (addr_match) seen_match_q <= 1'b1;
      else if (stop_event) seen_match_q <= 1'b0;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_quiet_R1: assert (!addr_match && !stop_event && !sda_oe)
            else $error("outputs active during reset");
      end
   end

   assert_match_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      addr_match |=> !addr_match);

   assert_stop_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_event |=> !stop_event);

   assert_oe_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !$past(scl_i));

   assert_group_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_event && group_cmd_en && !ten_bit_en) |-> seen_match_q);

   assert_stop_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stop_event |-> !sda_oe);
endmodule

bind i2c_addr_recognizer i2car_checker u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .scl_i        (scl_i),
   .ten_bit_en   (ten_bit_en),
   .group_cmd_en (group_cmd_en),
   .addr_match   (addr_match),
   .stop_event   (stop_event),
   .sda_oe       (sda_oe)
);

// File: tb/tb_i2c_addr_recognizer.sv
module tb_i2c_addr_recognizer;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic m_sda = 1'b1;
   logic [9:0] own_addr = '0;
   logic ten_bit_en = 1'b0;
   logic group_cmd_en = 1'b0;
   logic addr_match, dir, stop_event, sda_oe;
   logic sda_line;

   int n_checks = 0;
   int n_fail = 0;
   int n_match = 0;
   int n_stop = 0;
   int pulse_err = 0;
   logic last_dir = 1'b0;
   logic prev_match = 1'b0;
   logic prev_stop = 1'b0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   assign sda_line = m_sda & ~sda_oe;

   i2c_addr_recognizer dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_i        (scl),
      .sda_i        (sda_line),
      .own_addr     (own_addr),
      .ten_bit_en   (ten_bit_en),
      .group_cmd_en (group_cmd_en),
      .addr_match   (addr_match),
      .dir          (dir),
      .stop_event   (stop_event),
      .sda_oe       (sda_oe)
   );

   always @(posedge clk) begin
      if (rst_n) begin
         if (addr_match) begin
            n_match  <= n_match + 1;
            last_dir <= dir;
         end
         if (stop_event) n_stop <= n_stop + 1;
         if ((prev_match && addr_match) || (prev_stop && stop_event)) pulse_err <= pulse_err + 1;
         prev_match <= addr_match;
         prev_stop  <= stop_event;
      end else begin
         prev_match <= 1'b0;
         prev_stop  <= 1'b0;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_start();
      m_sda = 1'b1; wait_cyc(2);
      scl = 1'b1;   wait_cyc(4);
      m_sda = 1'b0; wait_cyc(4);
      scl = 1'b0;   wait_cyc(4);
   endtask

   task automatic do_stop();
      m_sda = 1'b0; wait_cyc(2);
      scl = 1'b1;   wait_cyc(4);
      m_sda = 1'b1; wait_cyc(6);
   endtask

   task automatic send_byte(input logic [7:0] b, output int acked);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; wait_cyc(2);
         scl = 1'b1;   wait_cyc(4);
         scl = 1'b0;   wait_cyc(2);
      end
      m_sda = 1'b1; wait_cyc(2);
      scl = 1'b1;   wait_cyc(2);
      acked = sda_line ? 0 : 1;
      wait_cyc(2);
      scl = 1'b0;   wait_cyc(2);
   endtask

   task automatic do_reset();
      scl = 1'b1; m_sda = 1'b1;
      rst_n = 1'b0;
      wait_cyc(3);
      check("R1 addr_match in reset", int'(addr_match), 0);
      check("R1 stop_event in reset", int'(stop_event), 0);
      check("R1 sda_oe in reset", int'(sda_oe), 0);
      check("R1 dir in reset", int'(dir), 0);
      rst_n = 1'b1;
      wait_cyc(3);
   endtask

   // {own7, address byte, expect match, expect dir, expect ack}
   localparam logic [17:0] VEC [6] = '{
      {7'h2A, 8'h54, 1'b1, 1'b0, 1'b1},
      {7'h2A, 8'h55, 1'b1, 1'b1, 1'b1},
      {7'h2A, 8'h56, 1'b0, 1'b0, 1'b0},
      {7'h7F, 8'hFE, 1'b1, 1'b0, 1'b1},
      {7'h00, 8'h01, 1'b1, 1'b1, 1'b1},
      {7'h00, 8'h80, 1'b0, 1'b0, 1'b0}
   };

   initial begin
      int ack, m0, s0;
      do_reset();

      // R2 R3 R7: 7-bit table
      for (int v = 0; v < 6; v++) begin
         own_addr = {3'b000, VEC[v][17:11]};
         ten_bit_en = 1'b0; group_cmd_en = 1'b0;
         m0 = n_match; s0 = n_stop;
         do_start();
         send_byte(VEC[v][10:3], ack);
         do_stop();
         check("R2 match count", n_match - m0, int'(VEC[v][2]));
         if (VEC[v][2]) check("R2 dir", int'(last_dir), int'(VEC[v][1]));
         check("R3 ack", ack, int'(VEC[v][0]));
         check("R7 stop_event", n_stop - s0, 1);
      end

      // 10-bit, own = 0x2C5: write hdr F4, read hdr F5
      own_addr = 10'h2C5; ten_bit_en = 1'b1; group_cmd_en = 1'b1;
      m0 = n_match; s0 = n_stop;
      do_start();
      send_byte(8'hF4, ack);
      check("R4 first byte ack", ack, 1);
      check("R4 no match on first byte", n_match - m0, 0);
      send_byte(8'hC5, ack);
      check("R4 low byte ack", ack, 1);
      check("R4 match", n_match - m0, 1);
      check("R4 dir write", int'(last_dir), 0);
      do_start();
      send_byte(8'hF5, ack);
      check("R5 read header ack", ack, 1);
      check("R5 read match", n_match - m0, 2);
      check("R5 dir read", int'(last_dir), 1);
      send_byte(8'h00, ack);
      check("R3 data byte not acked", ack, 0);
      do_stop();
      check("R7 stop in 10-bit with group", n_stop - s0, 1);

      m0 = n_match;
      do_start();
      send_byte(8'hF5, ack);
      do_stop();
      check("R6 read header after stop ack", ack, 0);
      check("R6 read header after stop match", n_match - m0, 0);

      do_start();
      send_byte(8'hF4, ack);
      send_byte(8'hC4, ack);
      check("R6 wrong low byte ack", ack, 0);
      do_start();
      send_byte(8'hF5, ack);
      do_stop();
      check("R6 read header after reject ack", ack, 0);
      check("R6 read header after reject match", n_match - m0, 0);

      do_start();
      send_byte(8'hF0, ack);
      do_stop();
      check("R10 other upper bits ack", ack, 0);
      do_start();
      send_byte(8'hE4, ack);
      do_stop();
      check("R10 bad tag ack", ack, 0);

      // R1: reset in mid transfer forgets 10-bit selection
      do_start();
      send_byte(8'hF4, ack);
      send_byte(8'hC5, ack);
      do_reset();
      m0 = n_match;
      do_start();
      send_byte(8'hF5, ack);
      do_stop();
      check("R1 selection lost after reset", n_match - m0, 0);

      // Group command, 7-bit, own 0x2A
      own_addr = 10'h02A; ten_bit_en = 1'b0; group_cmd_en = 1'b1;
      s0 = n_stop;
      do_start();
      send_byte(8'h20, ack); send_byte(8'h11, ack);
      do_start();
      send_byte(8'h30, ack); send_byte(8'h22, ack);
      do_stop();
      check("R8 stop hidden when not addressed", n_stop - s0, 0);
      do_start();
      send_byte(8'h20, ack); send_byte(8'h11, ack);
      do_start();
      send_byte(8'h54, ack); send_byte(8'h33, ack);
      do_start();
      send_byte(8'h30, ack);
      do_stop();
      check("R8 stop reported when addressed", n_stop - s0, 1);
      do_start();
      send_byte(8'h20, ack);
      do_stop();
      check("R8 history cleared by stop", n_stop - s0, 1);
      group_cmd_en = 1'b0;
      do_start();
      send_byte(8'h20, ack);
      do_stop();
      check("R7 stop without group mode", n_stop - s0, 2);

      check("R9 single-cycle pulses", pulse_err, 0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule